// File: doc/BRIEF.md
# Configurable Local TDM Stream Multiplexer

This block carries four logical local TDM streams, each worth 32 byte channels per 125 us frame, over four serial output pins and four serial input pins. A 2-bit configuration input picks one of four pin layouts. Each layout sets the bit rate of every pin and how many logical streams are interleaved channel by channel onto it. One free-running frame counter, clocked at 16.384 MHz, drives all timing. On transmit, the block asks for the next byte of each active pin through a zero-latency fetch port, then shifts it out MSB first. On receive, it samples each active input pin in the middle of every bit. It then hands back each completed byte, tagged with the logical stream and channel it belongs to.

A new configuration value is picked up only when a frame begins, so a frame never mixes two layouts. The block is meant to sit between a switching memory, which answers the fetch port and accepts the received bytes, and the local serial devices.

Top module: `tdm_stream_mux`

## Requirements
- R1: While `rst_i` is high, every `ser_o` pin is 1, `rx_valid_o`, `tx_load_o` and `frame_o` are all 0, and the active layout is configuration 0. The first clock edge after reset is released starts frame cycle 0.
- R2: With `mode_i` = 0, every pin p carries stream p alone at 8 clocks per bit, giving 32 channels per pin.
- R3: With `mode_i` = 1, pin 0 carries streams 0 and 1 and pin 2 carries streams 2 and 3, both at 4 clocks per bit with 64 channels per pin.
- R4: With `mode_i` = 2, pin 0 carries all four streams at 2 clocks per bit with 128 channels.
- R5: With `mode_i` = 3, pins 0 and 1 carry streams 0 and 1 at 8 clocks per bit, and pin 2 carries streams 2 and 3 at 4 clocks per bit.
- R6: A pin shared by k streams with lowest stream b carries, in its pin channel n, stream b + (n mod k), channel n div k.
- R7: The byte for a pin channel is requested through `tx_load_o`/`tx_stream_o`/`tx_chan_o` in the clock just before that channel starts. It is taken from `tx_byte_i` in the same clock and sent MSB first, each bit held for the full bit time.
- R8: Output pins not used by the active configuration stay at 1.
- R9: Input pins not used by the active configuration never raise `rx_valid_o`, whatever level they carry.
- R10: An active input pin is sampled only in the clock at phase P/2 of each bit, where P is the bit length in clocks. Levels at the other phases have no effect.
- R11: One clock after the sample of a byte's last bit, `rx_valid_o` pulses for one clock with the byte (first received bit as MSB) and its stream and channel, decoded per R6.
- R12: A change on `mode_i` takes effect at the next frame start. The layout is taken from `mode_i` at the edge that begins frame cycle 0.
- R13: `frame_o` is high exactly in frame cycle 0 and repeats every 2048 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 16.384 MHz timing clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Pin layout select, 0 to 3 |
| frame_o | output | 1 | High in frame cycle 0 |
| tx_load_o | output | 4 | Per pin: byte fetch in this clock |
| tx_stream_o | output | 8 | Per pin: stream of the fetched byte (2 bits each) |
| tx_chan_o | output | 20 | Per pin: channel of the fetched byte (5 bits each) |
| tx_byte_i | input | 32 | Per pin: fetched byte, same clock (8 bits each) |
| ser_o | output | 4 | Serial output pins |
| ser_i | input | 4 | Serial input pins |
| rx_valid_o | output | 4 | Per pin: received byte pulse |
| rx_stream_o | output | 8 | Per pin: stream of the received byte |
| rx_chan_o | output | 20 | Per pin: channel of the received byte |
| rx_byte_o | output | 32 | Per pin: received byte |

## Verification
The hardest thing to show from the ports is that an input pin is read at one phase of each bit and nowhere else. A clean loopback would pass even if the sample point were off by a clock. The bench therefore loops every active output pin back to its input only in the mid-bit clock and drives the inverted level in all other clocks. It also drives random levels on unused input pins. Layout changes are issued mid-frame, in a frame's last cycle and twice within one frame, so deferral to the frame start is seen on every layout. The data pattern is re-seeded at frame ends, so stale or misaddressed bytes show up as miscompares.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

   typedef enum logic [1:0] {
      CFG_FOUR_SLOW = 2'd0,
      CFG_TWO_MID   = 2'd1,
      CFG_ONE_FAST  = 2'd2,
      CFG_MIXED     = 2'd3
   } mux_cfg_e;

   // Per-pin plan: used or not, log2 of streams sharing it, lowest stream
   typedef struct packed {
      logic       active;
      logic [1:0] lg_share;
      logic [1:0] first_stream;
   } pin_plan_t;

   function automatic pin_plan_t pin_plan(input logic [1:0] cfg, input int unsigned pin);
      pin_plan_t r;
      r = '{active: 1'b0, lg_share: 2'd0, first_stream: 2'd0};
      case (cfg)
         CFG_FOUR_SLOW: r = '{active: 1'b1, lg_share: 2'd0, first_stream: 2'(pin)};
         CFG_TWO_MID: begin
            if (pin == 0 || pin == 2)
               r = '{active: 1'b1, lg_share: 2'd1, first_stream: 2'(pin)};
         end
         CFG_ONE_FAST: begin
            if (pin == 0)
               r = '{active: 1'b1, lg_share: 2'd2, first_stream: 2'd0};
         end
         default: begin
            if (pin < 2)
               r = '{active: 1'b1, lg_share: 2'd0, first_stream: 2'(pin)};
            else if (pin == 2)
               r = '{active: 1'b1, lg_share: 2'd1, first_stream: 2'd2};
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
   parameter int FRAME_CLKS = 2048,
   localparam int CTRW = $clog2(FRAME_CLKS)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [1:0]      mode_i,
   output logic [CTRW-1:0] cnt_q,
   output logic [1:0]      cfg_q,
   output logic [CTRW-1:0] cnt_nxt,
   output logic [1:0]      cfg_nxt
);
   localparam logic [CTRW-1:0] LAST = CTRW'(FRAME_CLKS - 1);

   always_comb begin
      cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      cfg_nxt = (cnt_nxt == '0) ? mode_i : cfg_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= LAST;
         cfg_q <= 2'd0;
      end else begin
         cnt_q <= cnt_nxt;
         cfg_q <= cfg_nxt;
      end
   end
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
   import tdm_mux_pkg::*;
#(
   parameter int PIN     = 0,
   parameter int LG_SLOW = 3,
   parameter int LG_BW   = 3,
   parameter int CTRW    = 11,
   parameter int CHW     = 5
) (
   input  logic [CTRW-1:0]  cnt_i,
   input  logic [1:0]       cfg_i,
   output logic             active_o,
   output logic             bit_start_o,
   output logic             bit_mid_o,
   output logic [LG_BW-1:0] bit_idx_o,
   output logic [1:0]       stream_o,
   output logic [CHW-1:0]   chan_o
);
   pin_plan_t       plan;
   int              lg_bit;
   logic [CTRW-1:0] phase;
   logic [1:0]      share_mask;

   always_comb begin
      plan        = pin_plan(cfg_i, PIN);
      lg_bit      = LG_SLOW - int'(plan.lg_share);
      phase       = cnt_i & ((CTRW'(1) << lg_bit) - CTRW'(1));
      active_o    = plan.active;
      bit_start_o = (phase == '0);
      bit_mid_o   = (phase == (CTRW'(1) << (lg_bit - 1)));
      bit_idx_o   = LG_BW'((cnt_i >> lg_bit) & CTRW'((1 << LG_BW) - 1));
      share_mask  = 2'((1 << plan.lg_share) - 1);
      stream_o    = plan.first_stream + (2'(cnt_i >> (lg_bit + LG_BW)) & share_mask);
      chan_o      = CHW'(cnt_i >> (LG_SLOW + LG_BW));
   end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
   parameter int PIN     = 0,
   parameter int LG_SLOW = 3,
   parameter int LG_BW   = 3,
   parameter int CTRW    = 11,
   parameter int CHW     = 5,
   localparam int BW     = 1 << LG_BW
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CTRW-1:0] cnt_nxt_i,
   input  logic [1:0]      cfg_nxt_i,
   input  logic [BW-1:0]   byte_i,
   output logic            load_o,
   output logic [1:0]      stream_o,
   output logic [CHW-1:0]  chan_o,
   output logic            ser_o
);
   logic             active, bit_start, bit_mid;
   logic [LG_BW-1:0] bit_idx;
   logic [BW-1:0]    hold_q, cur_byte;

   tdm_slot_decode #(
      .PIN(PIN), .LG_SLOW(LG_SLOW), .LG_BW(LG_BW), .CTRW(CTRW), .CHW(CHW)
   ) u_dec (
      .cnt_i(cnt_nxt_i), .cfg_i(cfg_nxt_i), .active_o(active),
      .bit_start_o(bit_start), .bit_mid_o(bit_mid), .bit_idx_o(bit_idx),
      .stream_o(stream_o), .chan_o(chan_o)
   );

   always_comb begin
      load_o   = !rst_i && active && bit_start && (bit_idx == '0);
      cur_byte = load_o ? byte_i : hold_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hold_q <= '0;
         ser_o  <= 1'b1;
      end else begin
         if (load_o) hold_q <= byte_i;
         ser_o <= active ? cur_byte[LG_BW'(BW - 1) - bit_idx] : 1'b1;
      end
   end

   logic unused_mid;
   assign unused_mid = bit_mid;
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
   parameter int PIN     = 0,
   parameter int LG_SLOW = 3,
   parameter int LG_BW   = 3,
   parameter int CTRW    = 11,
   parameter int CHW     = 5,
   localparam int BW     = 1 << LG_BW
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CTRW-1:0] cnt_i,
   input  logic [1:0]      cfg_i,
   input  logic            ser_i,
   output logic            valid_o,
   output logic [1:0]      stream_o,
   output logic [CHW-1:0]  chan_o,
   output logic [BW-1:0]   byte_o
);
   logic             active, bit_start, bit_mid;
   logic [LG_BW-1:0] bit_idx;
   logic [1:0]       dec_stream;
   logic [CHW-1:0]   dec_chan;
   logic [BW-2:0]    shift_q;

   tdm_slot_decode #(
      .PIN(PIN), .LG_SLOW(LG_SLOW), .LG_BW(LG_BW), .CTRW(CTRW), .CHW(CHW)
   ) u_dec (
      .cnt_i(cnt_i), .cfg_i(cfg_i), .active_o(active),
      .bit_start_o(bit_start), .bit_mid_o(bit_mid), .bit_idx_o(bit_idx),
      .stream_o(dec_stream), .chan_o(dec_chan)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         shift_q  <= '0;
         valid_o  <= 1'b0;
         stream_o <= '0;
         chan_o   <= '0;
         byte_o   <= '0;
      end else begin
         valid_o <= 1'b0;
         if (active && bit_mid) begin
            shift_q <= {shift_q[BW-3:0], ser_i};
            if (bit_idx == LG_BW'(BW - 1)) begin
               valid_o  <= 1'b1;
               byte_o   <= {shift_q, ser_i};
               stream_o <= dec_stream;
               chan_o   <= dec_chan;
            end
         end
      end
   end

   logic unused_start;
   assign unused_start = bit_start;
endmodule

// File: rtl/tdm_stream_mux.sv
module tdm_stream_mux #(
   parameter int NUM_PINS      = 4,
   parameter int CH_PER_STREAM = 32,
   parameter int BYTE_W        = 8,
   parameter int SLOW_BIT_CLKS = 8,
   localparam int CHW        = $clog2(CH_PER_STREAM),
   localparam int LG_BW      = $clog2(BYTE_W),
   localparam int LG_SLOW    = $clog2(SLOW_BIT_CLKS),
   localparam int FRAME_CLKS = CH_PER_STREAM * BYTE_W * SLOW_BIT_CLKS,
   localparam int CTRW       = $clog2(FRAME_CLKS)
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic [1:0]                 mode_i,
   output logic                       frame_o,
   output logic [NUM_PINS-1:0]        tx_load_o,
   output logic [NUM_PINS*2-1:0]      tx_stream_o,
   output logic [NUM_PINS*CHW-1:0]    tx_chan_o,
   input  logic [NUM_PINS*BYTE_W-1:0] tx_byte_i,
   output logic [NUM_PINS-1:0]        ser_o,
   input  logic [NUM_PINS-1:0]        ser_i,
   output logic [NUM_PINS-1:0]        rx_valid_o,
   output logic [NUM_PINS*2-1:0]      rx_stream_o,
   output logic [NUM_PINS*CHW-1:0]    rx_chan_o,
   output logic [NUM_PINS*BYTE_W-1:0] rx_byte_o
);
   // Elaboration-time parameter checks
   if (NUM_PINS != 4) begin : g_bad_pins
      $error("tdm_stream_mux: the pin layouts are defined for exactly four pins");
   end
   if ((1 << LG_BW) != BYTE_W || BYTE_W < 4) begin : g_bad_byte
      $error("tdm_stream_mux: BYTE_W must be a power of two, at least 4");
   end
   if ((1 << LG_SLOW) != SLOW_BIT_CLKS || SLOW_BIT_CLKS < 8) begin : g_bad_slow
      $error("tdm_stream_mux: SLOW_BIT_CLKS must be a power of two, at least 8");
   end
   if ((1 << CHW) != CH_PER_STREAM || CH_PER_STREAM < 4) begin : g_bad_ch
      $error("tdm_stream_mux: CH_PER_STREAM must be a power of two, at least 4");
   end

   logic [CTRW-1:0] cnt_q, cnt_nxt;
   logic [1:0]      cfg_q, cfg_nxt;

   tdm_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
      .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i),
      .cnt_q(cnt_q), .cfg_q(cfg_q), .cnt_nxt(cnt_nxt), .cfg_nxt(cfg_nxt)
   );

   assign frame_o = !rst_i && (cnt_q == '0);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      tdm_tx_lane #(
         .PIN(p), .LG_SLOW(LG_SLOW), .LG_BW(LG_BW), .CTRW(CTRW), .CHW(CHW)
      ) u_tx (
         .clk_i(clk_i), .rst_i(rst_i),
         .cnt_nxt_i(cnt_nxt), .cfg_nxt_i(cfg_nxt),
         .byte_i(tx_byte_i[p*BYTE_W +: BYTE_W]),
         .load_o(tx_load_o[p]),
         .stream_o(tx_stream_o[p*2 +: 2]),
         .chan_o(tx_chan_o[p*CHW +: CHW]),
         .ser_o(ser_o[p])
      );

      tdm_rx_lane #(
         .PIN(p), .LG_SLOW(LG_SLOW), .LG_BW(LG_BW), .CTRW(CTRW), .CHW(CHW)
      ) u_rx (
         .clk_i(clk_i), .rst_i(rst_i),
         .cnt_i(cnt_q), .cfg_i(cfg_q),
         .ser_i(ser_i[p]),
         .valid_o(rx_valid_o[p]),
         .stream_o(rx_stream_o[p*2 +: 2]),
         .chan_o(rx_chan_o[p*CHW +: CHW]),
         .byte_o(rx_byte_o[p*BYTE_W +: BYTE_W])
      );
   end
endmodule

// File: rtl/tdm_stream_mux_chk.sv
module tdm_stream_mux_chk
   import tdm_mux_pkg::*;
#(
   parameter int NUM_PINS   = 4,
   parameter int FRAME_CLKS = 2048
) (
   input logic                clk_i,
   input logic                rst_i,
   input logic                frame_o,
   input logic [1:0]          cfg_q,
   input logic [NUM_PINS-1:0] ser_o,
   input logic [NUM_PINS-1:0] rx_valid_o,
   input logic [NUM_PINS-1:0] tx_load_o
);
   logic [NUM_PINS-1:0] pin_used;
   pin_plan_t           tmp_plan;
   int                  gap;
   logic                seen;

   always_comb begin
      for (int p = 0; p < NUM_PINS; p++) begin
         tmp_plan    = pin_plan(cfg_q, p);
         pin_used[p] = tmp_plan.active;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (frame_o) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   // R13
   frame_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      seen |-> (frame_o == (gap == FRAME_CLKS - 1)));

   // R13
   frame_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_o |=> !frame_o);

   // R12
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !frame_o |-> $stable(cfg_q));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
      // R8
      idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         !pin_used[p] |-> ser_o[p]);

      // R9
      unused_rx_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         rx_valid_o[p] |-> $past(pin_used[p]));

      // R11
      rx_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         rx_valid_o[p] |=> !rx_valid_o[p]);

      // R7
      fetch_used_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         tx_load_o[p] |=> pin_used[p]);
   end
endmodule

bind tdm_stream_mux tdm_stream_mux_chk #(
   .NUM_PINS(NUM_PINS), .FRAME_CLKS(FRAME_CLKS)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .frame_o(frame_o), .cfg_q(cfg_q),
   .ser_o(ser_o), .rx_valid_o(rx_valid_o), .tx_load_o(tx_load_o)
);

// File: tb/tdm_stream_mux_bench.sv
module tdm_stream_mux_bench;
   localparam int NP    = 4;
   localparam int CH    = 32;
   localparam int BW    = 8;
   localparam int SLOW  = 8;
   localparam int CHW   = 5;
   localparam int FRAME = CH * BW * SLOW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst = 1'b1;
   logic [1:0]       mode_drv = 2'd0;
   int               salt = 3;
   logic             run = 1'b0;
   logic             frame_o;
   logic [NP-1:0]    tx_load, ser_o, rx_valid;
   logic [NP-1:0]    ser_i = '0;
   logic [NP*2-1:0]  tx_stream, rx_stream;
   logic [NP*CHW-1:0] tx_chan, rx_chan;
   logic [NP*BW-1:0] tx_byte, rx_byte;

   int nvec = 0;
   int nbad = 0;

   tdm_stream_mux u_tdm_stream_mux (
      .clk_i(clk), .rst_i(rst), .mode_i(mode_drv), .frame_o(frame_o),
      .tx_load_o(tx_load), .tx_stream_o(tx_stream), .tx_chan_o(tx_chan),
      .tx_byte_i(tx_byte), .ser_o(ser_o), .ser_i(ser_i),
      .rx_valid_o(rx_valid), .rx_stream_o(rx_stream), .rx_chan_o(rx_chan),
      .rx_byte_o(rx_byte)
   );

   function automatic logic [7:0] pat(int s, int c, int sl);
      return 8'((s * 73 + c * 29 + sl * 5 + 1) & 255);
   endfunction

   // Layout per requirement R2..R5: used, streams sharing the pin, lowest stream
   function automatic void layout(int mode, int pin, output bit act, output int k, output int base);
      act = 0; k = 1; base = pin;
      case (mode)
         0: act = 1;
         1: begin act = (pin == 0 || pin == 2); k = 2; end
         2: begin act = (pin == 0); k = 4; base = 0; end
         default: begin
            if (pin < 2) act = 1;
            else if (pin == 2) begin act = 1; k = 2; end
         end
      endcase
   endfunction

   function automatic string mode_tag(int mode);
      case (mode)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   always_comb begin
      for (int p = 0; p < NP; p++)
         tx_byte[p*BW +: BW] = pat(int'(tx_stream[p*2 +: 2]), int'(tx_chan[p*CHW +: CHW]), salt);
   end

   task automatic check(bit ok, string tag, int act, int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Bench time model: frame cycle, layout and data seed per frame
   int fcb = FRAME - 1;
   int cur_mode = 0, prv_mode = 0, cur_salt = 3, prv_salt = 3;

   always @(posedge clk) begin
      if (rst) begin
         fcb = FRAME - 1; cur_mode = 0; prv_mode = 0; cur_salt = salt; prv_salt = salt;
      end else begin
         prv_mode = cur_mode;
         prv_salt = cur_salt;
         fcb = (fcb == FRAME - 1) ? 0 : fcb + 1;
         if (fcb == 0) begin
            cur_mode = int'(mode_drv);
            cur_salt = salt;
         end
      end
   end

   always @(negedge clk) begin
      if (run && !rst) begin
         // R13
         check(frame_o == (fcb == 0), $sformatf("R13 frame_o fc=%0d", fcb),
               int'(frame_o), int'(fcb == 0));
         for (int p = 0; p < NP; p++) begin
            bit act; int k, base, pb, n, b, expb;
            string tg;
            layout(cur_mode, p, act, k, base);
            if (!act) begin
               expb = 1;
               tg = "R8";
            end else begin
               pb = SLOW / k;
               n = fcb / (BW * pb);
               b = (fcb / pb) % BW;
               expb = int'(pat(base + n % k, n / k, cur_salt) >> (BW - 1 - b)) & 1;
               tg = (int'(mode_drv) != cur_mode) ? "R12" : {mode_tag(cur_mode), " R7"};
            end
            check(ser_o[p] == expb[0], $sformatf("%s tx pin %0d fc=%0d mode=%0d", tg, p, fcb, cur_mode),
                  int'(ser_o[p]), expb);
         end
         for (int p = 0; p < NP; p++) begin
            bit act; int k, base, pb, pf, n, s, c;
            bit expv;
            layout(prv_mode, p, act, k, base);
            pf = (fcb == 0) ? FRAME - 1 : fcb - 1;
            pb = SLOW / k;
            expv = act && ((pf / pb) % BW == BW - 1) && (pf % pb == pb / 2);
            check(rx_valid[p] == expv,
                  $sformatf("%s rx_valid pin %0d fc=%0d", act ? "R11" : "R9", p, fcb),
                  int'(rx_valid[p]), int'(expv));
            if (expv && rx_valid[p]) begin
               n = pf / (BW * pb);
               s = base + n % k;
               c = n / k;
               check(int'(rx_stream[p*2 +: 2]) == s, $sformatf("R6 rx stream pin %0d", p),
                     int'(rx_stream[p*2 +: 2]), s);
               check(int'(rx_chan[p*CHW +: CHW]) == c, $sformatf("R6 rx chan pin %0d", p),
                     int'(rx_chan[p*CHW +: CHW]), c);
               check(rx_byte[p*BW +: BW] == pat(s, c, prv_salt), $sformatf("R10 rx byte pin %0d", p),
                     int'(rx_byte[p*BW +: BW]), int'(pat(s, c, prv_salt)));
            end
         end
         // Loop back only at mid-bit, invert elsewhere, noise on unused pins
         for (int p = 0; p < NP; p++) begin
            bit act; int k, base, pb;
            layout(cur_mode, p, act, k, base);
            pb = SLOW / k;
            if (!act) ser_i[p] = 1'($urandom);
            else if (fcb % pb == pb / 2) ser_i[p] = ser_o[p];
            else ser_i[p] = ~ser_o[p];
         end
      end
   end

   task automatic goto(int t);
      do @(negedge clk); while (fcb != t);
      #1;
   endtask

   task automatic frames(int n);
      repeat (n) goto(FRAME - 1);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      // R1
      check(ser_o == '1, "R1 ser_o in reset", int'(ser_o), 'hF);
      check(rx_valid == '0, "R1 rx_valid in reset", int'(rx_valid), 0);
      check(tx_load == '0, "R1 tx_load in reset", int'(tx_load), 0);
      check(frame_o == 1'b0, "R1 frame_o in reset", int'(frame_o), 0);
      #1;
      rst = 1'b0;
      run = 1'b1;
      frames(2);
      goto(700);  mode_drv = 2'd1;
      goto(FRAME - 1); salt = 17; frames(2);
      goto(300);  mode_drv = 2'd2;
      goto(FRAME - 1); salt = 40; frames(2);
      mode_drv = 2'd3; salt = 99;
      frames(2);
      goto(1500); mode_drv = 2'd2;
      goto(1600); mode_drv = 2'd1;
      goto(FRAME - 1); salt = 123; frames(2);
      goto(10);   mode_drv = 2'd0;
      goto(FRAME - 1); salt = 201; frames(2);
      run = 1'b0;
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!finished) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule